// File: doc/BRIEF.md
# USB Host Controller Status and Ownership Register Slice

This block holds the operational register bytes of a USB host controller that software reaches through a byte-wide memory-mapped port. It decodes each byte write and applies the side effects tied to a small set of offsets. The command/status byte carries a software reset and an ownership-change request. The interrupt status bytes clear when a one is written to a bit. The top enable byte decides whether an ownership change raises a system-management interrupt (SMI). A write to the control byte that selects the reset functional state reloads the two root-hub port change bytes.

Register content lives in a window of `WIN_BYTES` bytes at the bottom of the address space. The offsets named below are fixed, because software and the neighbouring root-hub logic decode them. Interrupt sources outside the slice set status bits through a per-bit event input. Reads are combinational and change no state.

Top module: `usb_hc_ctl_slice`

## Requirements
- R1: While rst_ni is low and after it is released, byte 0x00 reads 0x10, byte 0x01 reads 0x01, byte 0x48 reads 0x02 and every other byte in the window reads 0x00.
- R2: A write to 0x08 with bit 0 set returns every byte to the R1 values, then stores the written value with bit 0 forced to 0 at 0x08. Bit 0 of 0x08 never reads as 1.
- R3: A write to 0x08 with bit 3 set and bit 0 clear sets byte 0x0F to exactly 0x40. If bit 0 is also set, the reset of R2 wins and 0x0F reads 0x00.
- R4: smi_o goes high for exactly one cycle, in the cycle after a write to 0x08 with bit 3 set, if bits 7 and 6 of byte 0x13 were both 1 before that write. Otherwise smi_o stays low.
- R5: A write to 0x0C clears each bit selected by (written value AND 0x7F). Bit 7 and the unselected bits keep their value.
- R6: Writes to 0x0D and 0x0E leave those bytes unchanged.
- R7: A write to 0x0F clears bit 6 when the written bit 6 is 1 and changes nothing else.
- R8: A write to 0x04 stores the value. When written bits 7:6 are 00, bytes 0x56 and 0x5A are also loaded with 0x16.
- R9: Any other byte inside the window is plain read/write. A write whose address lies above the window changes nothing, and a read there returns 0x00.
- R10: rdata_o shows the byte at addr_i in the same cycle, and a read alters no state.
- R11: A bit set in evt_i sets the matching bit of 0x0C at the next edge. When a clearing write to 0x0C and an event hit the same bit in one cycle, the bit ends set. During a software reset, events are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | ADDR_W | Byte address used for both read and write |
| wdata_i | input | 8 | Write data |
| evt_i | input | 8 | Interrupt event set bits for byte 0x0C |
| rdata_o | output | 8 | Combinational read data |
| smi_o | output | 1 | System-management interrupt pulse |

## Verification
A write or an event captured at a clock edge shows on rdata_o straight after that edge, and smi_o rises at the same edge and falls at the next one. Every write in the bench is followed at once by a readback of the written address together with the expected smi_o level. The next access checks smi_o low again. The monitor samples both outputs on the falling edge in the middle of that access, so each expectation lines up with the single edge that produced it.

// File: rtl/usb_hc_pkg.sv
package usb_hc_pkg;
  localparam int OFF_CTRL    = 'h04;
  localparam int OFF_CMD     = 'h08;
  localparam int OFF_IST0    = 'h0C;
  localparam int OFF_IST1    = 'h0D;
  localparam int OFF_IST2    = 'h0E;
  localparam int OFF_IST3    = 'h0F;
  localparam int OFF_IEN3    = 'h13;
  localparam int OFF_RH_DESC = 'h48;
  localparam int OFF_PCHG0   = 'h56;
  localparam int OFF_PCHG1   = 'h5A;

  localparam logic [7:0] CMD_SWRST_BIT = 8'h01;
  localparam logic [7:0] CMD_OWN_BIT   = 8'h08;
  localparam logic [7:0] IST0_W1C_MASK = 8'h7F;
  localparam logic [7:0] IST3_OWN_MASK = 8'h40;
  localparam logic [7:0] PCHG_FS_LOAD  = 8'h16;

  function automatic logic [7:0] reset_byte(int idx);
    case (idx)
      'h00:        reset_byte = 8'h10;
      'h01:        reset_byte = 8'h01;
      OFF_RH_DESC: reset_byte = 8'h02;
      default:     reset_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hc_wr_decode.sv
module hc_wr_decode #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 7
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              in_win_o,
  output logic              wr_hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              soft_rst_o,
  output logic              own_req_o,
  output logic              fs_reset_o
);
  import usb_hc_pkg::*;

  assign in_win_o = (addr_i[ADDR_W-1:IDX_W] == '0);
  assign idx_o    = addr_i[IDX_W-1:0];
  assign wr_hit_o = wr_en_i && in_win_o;

  logic cmd_hit;
  assign cmd_hit    = wr_hit_o && (int'(idx_o) == OFF_CMD);
  assign soft_rst_o = cmd_hit && ((wdata_i & CMD_SWRST_BIT) != 8'h00);
  assign own_req_o  = cmd_hit && ((wdata_i & CMD_OWN_BIT) != 8'h00);
  assign fs_reset_o = wr_hit_o && (int'(idx_o) == OFF_CTRL) && (wdata_i[7:6] == 2'b00);
endmodule

// File: rtl/hc_reg_bank.sv
module hc_reg_bank #(
  parameter int NB    = 128,
  parameter int IDX_W = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_hit_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [7:0]          wdata_i,
  input  logic                soft_rst_i,
  input  logic                own_req_i,
  input  logic                fs_reset_i,
  input  logic [7:0]          evt_i,
  output logic [NB-1:0][7:0]  regs_o
);
  import usb_hc_pkg::*;

  logic [NB-1:0][7:0] q, nxt;

  always_comb begin
    nxt = q;
    if (soft_rst_i) begin
      for (int i = 0; i < NB; i++) nxt[i] = reset_byte(i);
      nxt[OFF_CMD] = wdata_i & ~CMD_SWRST_BIT;
    end else begin
      nxt[OFF_IST0] = q[OFF_IST0] | evt_i;
      if (wr_hit_i) begin
        case (int'(idx_i))
          OFF_IST0: nxt[OFF_IST0] = (q[OFF_IST0] & ~(wdata_i & IST0_W1C_MASK)) | evt_i;
          OFF_IST1, OFF_IST2: ;
          OFF_IST3: nxt[OFF_IST3] = q[OFF_IST3] & ~(wdata_i & IST3_OWN_MASK);
          OFF_CMD: begin
            nxt[OFF_CMD] = wdata_i & ~CMD_SWRST_BIT;
            if (own_req_i) nxt[OFF_IST3] = IST3_OWN_MASK;
          end
          OFF_CTRL: begin
            nxt[OFF_CTRL] = wdata_i;
            if (fs_reset_i) begin
              nxt[OFF_PCHG0] = PCHG_FS_LOAD;
              nxt[OFF_PCHG1] = PCHG_FS_LOAD;
            end
          end
          default: nxt[idx_i] = wdata_i;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) q[i] <= reset_byte(i);
    end else begin
      q <= nxt;
    end
  end

  assign regs_o = q;

  // R2: software reset reloads defaults
  assert_swrst_defaults_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (q['h00] == 8'h10 && q['h01] == 8'h01 && q[OFF_RH_DESC] == 8'h02
                    && q[OFF_IST0] == 8'h00 && !q[OFF_CMD][0]));
  // R3: ownership request latches status
  assert_own_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_req_i && !soft_rst_i) |=> (q[OFF_IST3] == 8'h40));
  // R5: write-one-to-clear
  assert_w1c_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && int'(idx_i) == OFF_IST0 && evt_i == 8'h00)
      |=> ((q[OFF_IST0] & $past(wdata_i & IST0_W1C_MASK)) == 8'h00));
  // R6: read-only status bytes
  assert_ist1_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && int'(idx_i) == OFF_IST1 && !soft_rst_i) |=> $stable(q[OFF_IST1]));
  // R8: functional-state reset loads port change bytes
  assert_fs_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_reset_i |=> (q[OFF_PCHG0] == 8'h16 && q[OFF_PCHG1] == 8'h16));
endmodule

// File: rtl/hc_smi_gen.sv
module hc_smi_gen (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       own_req_i,
  input  logic [1:0] smi_en_i,
  output logic       smi_o
);
  logic smi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_q <= 1'b0;
    else         smi_q <= own_req_i && (smi_en_i == 2'b11);
  end

  assign smi_o = smi_q;

  // R4: pulse follows an enabled request, and only that
  assert_smi_fire_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_req_i && smi_en_i == 2'b11) |=> smi_o);
  assert_smi_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_req_i |=> !smi_o);
endmodule

// File: rtl/usb_hc_ctl_slice.sv
module usb_hc_ctl_slice #(
  parameter int ADDR_W    = 12,
  parameter int WIN_BYTES = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        evt_i,
  output logic [7:0]        rdata_o,
  output logic              smi_o
);
  import usb_hc_pkg::*;

  localparam int IDX_W = $clog2(WIN_BYTES);

  logic                       in_win, wr_hit, soft_rst, own_req, fs_reset;
  logic [IDX_W-1:0]           idx;
  logic [WIN_BYTES-1:0][7:0]  regs;

  hc_wr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_dec (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .in_win_o  (in_win),
    .wr_hit_o  (wr_hit),
    .idx_o     (idx),
    .soft_rst_o(soft_rst),
    .own_req_o (own_req),
    .fs_reset_o(fs_reset)
  );

  hc_reg_bank #(.NB(WIN_BYTES), .IDX_W(IDX_W)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_hit_i  (wr_hit),
    .idx_i     (idx),
    .wdata_i   (wdata_i),
    .soft_rst_i(soft_rst),
    .own_req_i (own_req),
    .fs_reset_i(fs_reset),
    .evt_i     (evt_i),
    .regs_o    (regs)
  );

  hc_smi_gen i_smi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .own_req_i(own_req),
    .smi_en_i (regs[OFF_IEN3][7:6]),
    .smi_o    (smi_o)
  );

  assign rdata_o = in_win ? regs[idx] : 8'h00;
endmodule

// File: tb/test_usb_hc_ctl_slice.sv
module test_usb_hc_ctl_slice;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  evt_i = '0;
  logic [7:0]  rdata_o;
  logic        smi_o;

  usb_hc_ctl_slice i_usb_hc_ctl_slice (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .evt_i(evt_i), .rdata_o(rdata_o), .smi_o(smi_o)
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [11:0] addr;
    logic [7:0]  rd;
    logic        smi;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [7:0]  model [0:127];
  bit          done = 1'b0;

  always @(negedge clk_i) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata_o !== it.rd || smi_o !== it.smi) begin
        errors++;
        $display("FAIL %s addr=%h rdata=%h smi=%b expected rdata=%h smi=%b",
                 it.tag, it.addr, rdata_o, smi_o, it.rd, it.smi);
      end
    end
  end

  function automatic logic [7:0] exp_rd(logic [11:0] a);
    return (a < 12'h080) ? model[a[6:0]] : 8'h00;
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    model[8'h00] = 8'h10;
    model[8'h01] = 8'h01;
    model[8'h48] = 8'h02;
  endtask

  task automatic push(logic [11:0] a, logic s, string tag);
    item_t it;
    addr_i = a;
    it.addr = a; it.rd = exp_rd(a); it.smi = s; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic rd(logic [11:0] a, string tag);
    push(a, 1'b0, tag);
    @(posedge clk_i); #1;
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d, string tag);
    logic s;
    int   k;
    s = (a == 12'h008) && d[3] && (model[8'h13][7:6] == 2'b11);
    if (a < 12'h080) begin
      k = int'(a);
      if (k == 8'h08) begin
        if (d[0]) model_defaults();
        else if (d[3]) model[8'h0F] = 8'h40;
        model[8'h08] = d & 8'hFE;
      end else if (k == 8'h0C) model[k] = model[k] & ~(d & 8'h7F);
      else if (k == 8'h0D || k == 8'h0E) ;
      else if (k == 8'h0F) model[k] = model[k] & ~(d & 8'h40);
      else if (k == 8'h04) begin
        model[k] = d;
        if (d[7:6] == 2'b00) begin model[8'h56] = 8'h16; model[8'h5A] = 8'h16; end
      end else model[k] = d;
    end
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    push(a, s, tag);
    @(posedge clk_i); #1;
  endtask

  task automatic evt(logic [7:0] v, string tag);
    evt_i = v;
    @(posedge clk_i); #1;
    evt_i = 8'h00;
    model[8'h0C] = model[8'h0C] | v;
    rd(12'h00C, tag);
  endtask

  initial begin
    model_defaults();
    #2;
    push(12'h000, 1'b0, "R1 reset byte0");
    #10 push(12'h048, 1'b0, "R1 reset byte48");
    #10 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    rd(12'h001, "R1 byte1");
    rd(12'h004, "R1 ctrl zero");
    rd(12'h013, "R10 read no side effect");
    rd(12'h013, "R10 read repeat");

    wr(12'h020, 8'hA5, "R9 plain rw");
    wr(12'h820, 8'h3C, "R9 out of window write");
    rd(12'h020, "R9 window byte untouched");
    rd(12'h820, "R9 out of window read zero");

    evt(8'hFF, "R11 event sets status");
    wr(12'h00C, 8'hF0, "R5 w1c upper nibble");
    wr(12'h00C, 8'h0F, "R5 w1c lower, bit7 kept");
    rd(12'h00C, "R5 bit7 stays");
    // R11 set wins over clear in the same cycle
    evt_i = 8'h01; wr_en_i = 1'b1; addr_i = 12'h00C; wdata_i = 8'h01;
    @(posedge clk_i); #1;
    evt_i = 8'h00; wr_en_i = 1'b0;
    model[8'h0C] = model[8'h0C] | 8'h01;
    rd(12'h00C, "R11 set beats clear");

    wr(12'h00D, 8'hFF, "R6 byte0D ignores");
    wr(12'h00E, 8'hFF, "R6 byte0E ignores");

    wr(12'h008, 8'h08, "R3 own request no smi");
    rd(12'h00F, "R3 own status 0x40");
    wr(12'h00F, 8'hBF, "R7 no clear without bit6");
    wr(12'h00F, 8'h40, "R7 clear bit6");

    wr(12'h013, 8'h80, "R9 enable partial");
    wr(12'h008, 8'h08, "R4 partial enable no smi");
    wr(12'h013, 8'hC0, "R9 enable full");
    wr(12'h008, 8'h0C, "R4 smi pulse");
    rd(12'h00F, "R4 smi single cycle");
    wr(12'h008, 8'h00, "R4 no request no smi");

    wr(12'h004, 8'h80, "R8 ctrl operational no load");
    rd(12'h056, "R8 port chg untouched");
    wr(12'h004, 8'h3F, "R8 ctrl reset state");
    rd(12'h056, "R8 port chg0 loaded");
    rd(12'h05A, "R8 port chg1 loaded");

    wr(12'h008, 8'h09, "R2 soft reset with own smi");
    rd(12'h00F, "R3 reset wins own status");
    rd(12'h000, "R2 byte0 default");
    rd(12'h048, "R2 byte48 default");
    rd(12'h020, "R2 plain byte cleared");
    rd(12'h056, "R2 port chg cleared");
    rd(12'h008, "R2 reset bit reads zero");
    wr(12'h008, 8'h01, "R2 reset bit self clears");

    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule